// File: doc/BRIEF.md
# Tape Controller Command and Status Registers

This block is the register front end of a block-addressed tape controller. It holds a command register, a status register and a data register on a simple 16-bit register bus that has per-byte write strobes. The command register carries a 3-bit function code, a unit number, an interrupt enable, a GO bit, a DONE flag and an ERROR summary bit. The status register holds the individual error flags and the tape motion state. The data register is the word buffer for transfers.

The block does not wait for a GO bit to start a command. Every write to the command register issues a command, and the function code held after that write selects what happens. It can start the selected tape, stop it, or reject the command and raise an error flag. The block also decides when DONE is set or cleared and when the interrupt request rises. Toward the drive it exchanges only a select-error input, an operation-complete pulse, the unit number and a motion-enable level.

Register addresses: 0 is status (read-only), 1 is command, 2 is data. Command bits: 0 GO (reads 0), 3:1 function, 6 IE, 7 DONE (read-only), 10:8 unit, 15 ERROR. Status bits: 15 select error, 14 illegal operation, 0 motion. Function codes: 0 stop-all, 1 stop, 2 search, 3 read-all, 4 write-all, 5 write-mark, 6 read, 7 illegal.

Top module: `tapectl_regs`

## Requirements
- R1: After reset the command register reads 0x0080 (DONE set, function 0, IE 0, unit 0), status reads 0, motionOn and irqReq are low.
- R2: Any command-register write whose resulting function is 2 to 6 starts motion (motionOn high), with GO written 0 or 1 and with either byte lane, provided selErr is low. Functions 0 and 1 stop motion.
- R3: A write with the low byte lane enabled and GO (bit 0) at 1 clears DONE (command bit 7) and both status error bits.
- R4: Writing ERROR (command bit 15) as 0 with the high byte lane enabled clears both status error bits. A low-lane-only write, or writing ERROR as 1, leaves them unchanged.
- R5: With selErr high, function 0 still stops motion and sets no error. Any other function is rejected: status bit 15 sets and motion stops.
- R6: Function 7 sets status bit 14 and stops motion.
- R7: A data-register write clears DONE when the held function is 3, 4 or 5. It leaves DONE alone for other functions. Byte lanes update only their own half of the data register.
- R8: A data-register read clears DONE only when the held function is 3.
- R9: Command bit 15 reads as the OR of status bits 15 and 14.
- R10: An opDone pulse sets DONE. A further opDone while DONE is already set produces no new interrupt.
- R11: irqReq rises when DONE rises with IE set, or when IE goes from 0 to 1 with DONE still set after the write. A write that sets IE and GO together raises no request. The request holds until irqAck pulses or IE is cleared.
- R12: The unit field (command bits 10:8), written through the high byte lane, drives unitSel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (for read side effects) |
| busBe | input | 2 | Byte lane enables, bit 1 = high byte |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr (combinational) |
| selErr | input | 1 | Drive reports the selected unit is unusable |
| opDone | input | 1 | Operation-complete pulse from the drive side |
| irqAck | input | 1 | Interrupt acknowledge pulse |
| unitSel | output | 3 | Selected unit number |
| motionOn | output | 1 | Tape motion enable |
| irqReq | output | 1 | Interrupt request |

## Verification
A DONE flag stuck in the wrong state shows up directly at command bit 7 on the next read. It also shows up at irqReq one cycle after the write or completion that should have moved it. An error flag cleared or kept wrongly, for example by honouring the wrong byte lane, changes the status word and command bit 15 on the next read. A misordered interrupt decision is the subtle case: evaluating DONE before GO is applied raises irqReq in the very cycle after a combined IE-and-GO write. The bench therefore samples irqReq right after each such write and after each acknowledge.

// File: rtl/tapectl_pkg.sv
package tapectl_pkg;
  localparam int DATA_W = 16;
  localparam int FN_W   = 3;
  localparam int UNIT_W = 3;
  localparam int ADDR_W = 2;
  localparam int BE_W   = DATA_W / 8;

  localparam logic [ADDR_W-1:0] A_STAT = 2'd0;
  localparam logic [ADDR_W-1:0] A_CMD  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DATA = 2'd2;

  // command word bit positions
  localparam int C_GO   = 0;
  localparam int C_FN   = 1;
  localparam int C_IE   = 6;
  localparam int C_DONE = 7;
  localparam int C_UNIT = 8;
  localparam int C_ERR  = 15;
  // status word bit positions
  localparam int S_SEL  = 15;
  localparam int S_ILL  = 14;
  localparam int S_MOT  = 0;

  typedef enum logic [FN_W-1:0] {
    FN_STOP_ALL = 3'd0,
    FN_STOP     = 3'd1,
    FN_SEARCH   = 3'd2,
    FN_RD_ALL   = 3'd3,
    FN_WR_ALL   = 3'd4,
    FN_WR_MARK  = 3'd5,
    FN_RD_DATA  = 3'd6,
    FN_ILLEGAL  = 3'd7
  } func_e;

  typedef struct packed {
    logic cmdLoLd;
    logic cmdHiLd;
    logic dataLoLd;
    logic dataHiLd;
    logic goClr;
    logic errClr;
    logic doneClr;
    logic setSelErr;
    logic setIll;
    logic motStart;
    logic motStop;
  } strobe_t;
endpackage

// File: rtl/tapectl_ctrl.sv
module tapectl_ctrl
  import tapectl_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              selErr,
  input  func_e             fnQ,
  output strobe_t           strb
);
  logic  cmdWr, dataWr, dataRd, xferFn;
  func_e fnNew;

  always_comb begin
    cmdWr  = busWr && (busAddr == A_CMD) && (|busBe);
    dataWr = busWr && (busAddr == A_DATA) && (|busBe);
    dataRd = busRd && (busAddr == A_DATA);
    fnNew  = busBe[0] ? func_e'(busWdata[C_FN +: FN_W]) : fnQ;
    xferFn = (fnQ == FN_RD_ALL) || (fnQ == FN_WR_ALL) || (fnQ == FN_WR_MARK);

    strb          = '0;
    strb.cmdLoLd  = cmdWr && busBe[0];
    strb.cmdHiLd  = cmdWr && busBe[1];
    strb.dataLoLd = dataWr && busBe[0];
    strb.dataHiLd = dataWr && busBe[1];
    strb.goClr    = strb.cmdLoLd && busWdata[C_GO];
    strb.errClr   = strb.cmdHiLd && !busWdata[C_ERR];
    strb.doneClr  = strb.goClr || (dataWr && xferFn) ||
                    (dataRd && (fnQ == FN_RD_ALL));

    if (cmdWr) begin
      if (fnNew == FN_STOP_ALL) begin
        strb.motStop = 1'b1;
      end else if (selErr) begin
        strb.setSelErr = 1'b1;
        strb.motStop   = 1'b1;
      end else if (fnNew == FN_ILLEGAL) begin
        strb.setIll  = 1'b1;
        strb.motStop = 1'b1;
      end else if (fnNew == FN_STOP) begin
        strb.motStop = 1'b1;
      end else begin
        strb.motStart = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tapectl_dpath.sv
module tapectl_dpath
  import tapectl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              selErr,
  input  logic              opDone,
  input  logic              irqAck,
  output func_e             fnQ,
  output logic [DATA_W-1:0] busRdata,
  output logic [UNIT_W-1:0] unitSel,
  output logic              motionOn,
  output logic              irqReq
);
  logic              ieQ, doneQ, errSelQ, errIllQ, motionQ, irqQ;
  logic [UNIT_W-1:0] unitQ;
  logic [DATA_W-1:0] dataQ;
  logic              ieNext, doneNext, irqSet, irqNext, errWipe;

  always_comb begin
    ieNext   = strb.cmdLoLd ? busWdata[C_IE] : ieQ;
    // GO clear is applied before the interrupt decision looks at DONE
    doneNext = strb.doneClr ? 1'b0 : (doneQ | opDone);
    irqSet   = ieNext && doneNext && (!doneQ || !ieQ);
    irqNext  = ieNext && (irqSet || (irqQ && !irqAck));
    errWipe  = strb.goClr || strb.errClr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fnQ     <= FN_STOP_ALL;
      ieQ     <= 1'b0;
      doneQ   <= 1'b1;
      unitQ   <= '0;
      errSelQ <= 1'b0;
      errIllQ <= 1'b0;
      motionQ <= 1'b0;
      irqQ    <= 1'b0;
      dataQ   <= '0;
    end else begin
      if (strb.cmdLoLd) fnQ   <= func_e'(busWdata[C_FN +: FN_W]);
      if (strb.cmdHiLd) unitQ <= busWdata[C_UNIT +: UNIT_W];
      if (strb.dataLoLd) dataQ[7:0]        <= busWdata[7:0];
      if (strb.dataHiLd) dataQ[DATA_W-1:8] <= busWdata[DATA_W-1:8];
      ieQ     <= ieNext;
      doneQ   <= doneNext;
      irqQ    <= irqNext;
      errSelQ <= (errSelQ && !errWipe) || strb.setSelErr;
      errIllQ <= (errIllQ && !errWipe) || strb.setIll;
      if (strb.motStart)     motionQ <= 1'b1;
      else if (strb.motStop) motionQ <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      A_STAT: begin
        busRdata[S_SEL] = errSelQ;
        busRdata[S_ILL] = errIllQ;
        busRdata[S_MOT] = motionQ;
      end
      A_CMD: begin
        busRdata[C_FN +: FN_W]     = fnQ;
        busRdata[C_IE]             = ieQ;
        busRdata[C_DONE]           = doneQ;
        busRdata[C_UNIT +: UNIT_W] = unitQ;
        busRdata[C_ERR]            = errSelQ | errIllQ;
      end
      A_DATA:  busRdata = dataQ;
      default: busRdata = '0;
    endcase
  end

  assign unitSel  = unitQ;
  assign motionOn = motionQ;
  assign irqReq   = irqQ;

  p_go_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.goClr && !strb.setSelErr && !strb.setIll) |=> (!doneQ && !errSelQ && !errIllQ));
  p_err_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.goClr || strb.errClr) |=> (!$fell(errSelQ) && !$fell(errIllQ)));
  p_no_start_on_selerr_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(motionQ) |-> !$past(selErr));
  p_irq_needs_ie_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> ieQ);
  p_no_irq_ie_go_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ieQ) && !doneQ) |-> !irqQ);
  p_done_rise_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(doneQ) && ieQ) |-> irqQ);
endmodule

// File: rtl/tapectl_regs.sv
module tapectl_regs
  import tapectl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BE_W-1:0]   busBe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              selErr,
  input  logic              opDone,
  input  logic              irqAck,
  output logic [UNIT_W-1:0] unitSel,
  output logic              motionOn,
  output logic              irqReq
);
  strobe_t strb;
  func_e   fnQ;

  tapectl_ctrl u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .busBe(busBe),
    .busWdata(busWdata), .selErr(selErr), .fnQ(fnQ), .strb(strb)
  );

  tapectl_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .selErr(selErr), .opDone(opDone), .irqAck(irqAck),
    .fnQ(fnQ), .busRdata(busRdata), .unitSel(unitSel),
    .motionOn(motionOn), .irqReq(irqReq)
  );
endmodule

// File: tb/tapectl_regs_test.sv
module tapectl_regs_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  busAddr = '0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [1:0]  busBe = '0;
  logic [15:0] busWdata = '0;
  logic [15:0] busRdata;
  logic        selErr = 1'b0, opDone = 1'b0, irqAck = 1'b0;
  logic [2:0]  unitSel;
  logic        motionOn, irqReq;
  int          total = 0, bad = 0;
  logic [15:0] rv;

  always #5 clk = ~clk;

  tapectl_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busBe(busBe), .busWdata(busWdata), .busRdata(busRdata), .selErr(selErr),
    .opDone(opDone), .irqAck(irqAck), .unitSel(unitSel),
    .motionOn(motionOn), .irqReq(irqReq)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    busAddr = a; busBe = be; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busBe = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); opDone = 1'b1;
    @(negedge clk); opDone = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); irqAck = 1'b1;
    @(negedge clk); irqAck = 1'b0;
  endtask

  task automatic doneBit(input string req, input logic exp);
    logic [15:0] c;
    rd(2'd1, c);
    chk(req, {15'd0, c[7]}, {15'd0, exp});
  endtask

  task automatic testReset();
    rd(2'd1, rv); chk("R1 cmd", rv, 16'h0080);
    rd(2'd0, rv); chk("R1 status", rv, 16'h0000);
    chk("R1 motion", {15'd0, motionOn}, 16'd0);
    chk("R1 irq", {15'd0, irqReq}, 16'd0);
  endtask

  task automatic testMotion();
    wr(2'd1, 2'b01, 16'h0004); chk("R2 search starts", {15'd0, motionOn}, 16'd1);
    wr(2'd1, 2'b01, 16'h0002); chk("R2 stop", {15'd0, motionOn}, 16'd0);
    wr(2'd1, 2'b01, 16'h000C); chk("R2 read starts", {15'd0, motionOn}, 16'd1);
    wr(2'd1, 2'b01, 16'h0000); chk("R2 stop all", {15'd0, motionOn}, 16'd0);
  endtask

  task automatic testSelect();
    wr(2'd1, 2'b01, 16'h0004);
    selErr = 1'b1;
    wr(2'd1, 2'b01, 16'h0004);
    chk("R5 rejected stops", {15'd0, motionOn}, 16'd0);
    rd(2'd0, rv); chk("R5 sel flag", rv, 16'h8000);
    rd(2'd1, rv); chk("R9 err summary sel", rv, 16'h8084);
    selErr = 1'b0;
    wr(2'd1, 2'b10, 16'h0000);
    rd(2'd0, rv); chk("R4 high lane clear", rv, 16'h0001);
    selErr = 1'b1;
    wr(2'd1, 2'b01, 16'h0000);
    chk("R5 stop all stops", {15'd0, motionOn}, 16'd0);
    rd(2'd0, rv); chk("R5 stop all no error", rv, 16'h0000);
    selErr = 1'b0;
  endtask

  task automatic testIllegal();
    wr(2'd1, 2'b01, 16'h0004);
    wr(2'd1, 2'b01, 16'h000E);
    chk("R6 illegal stops", {15'd0, motionOn}, 16'd0);
    rd(2'd0, rv); chk("R6 ill flag", rv, 16'h4000);
    rd(2'd1, rv); chk("R9 err summary ill", rv, 16'h808E);
    wr(2'd1, 2'b01, 16'h0002);
    rd(2'd0, rv); chk("R4 low lane keeps", rv, 16'h4000);
    wr(2'd1, 2'b10, 16'h8500);
    rd(2'd0, rv); chk("R4 err=1 keeps", rv, 16'h4000);
    chk("R12 unit", {13'd0, unitSel}, 16'd5);
    wr(2'd1, 2'b10, 16'h0500);
    rd(2'd0, rv); chk("R4 err=0 clears", rv, 16'h0000);
  endtask

  task automatic testGo();
    wr(2'd1, 2'b01, 16'h000E);
    wr(2'd1, 2'b01, 16'h0003);
    rd(2'd0, rv); chk("R3 go clears errors", rv, 16'h0000);
    rd(2'd1, rv); chk("R3 go clears done", rv, 16'h0502);
  endtask

  task automatic testIrq();
    wr(2'd1, 2'b01, 16'h0042);
    chk("R11 ie with done low", {15'd0, irqReq}, 16'd0);
    pulseDone();
    chk("R10 done rise irq", {15'd0, irqReq}, 16'd1);
    pulseAck();
    chk("R11 ack drops", {15'd0, irqReq}, 16'd0);
    pulseDone();
    chk("R10 second done no irq", {15'd0, irqReq}, 16'd0);
    doneBit("R10 done set", 1'b1);
    wr(2'd1, 2'b01, 16'h0002);
    wr(2'd1, 2'b01, 16'h0042);
    chk("R11 ie rise with done", {15'd0, irqReq}, 16'd1);
    pulseAck();
    wr(2'd1, 2'b01, 16'h0002);
    wr(2'd1, 2'b01, 16'h0043);
    chk("R11 ie+go no irq", {15'd0, irqReq}, 16'd0);
    pulseDone();
    chk("R11 done rise again", {15'd0, irqReq}, 16'd1);
    wr(2'd1, 2'b01, 16'h0002);
    chk("R11 ie clear drops", {15'd0, irqReq}, 16'd0);
  endtask

  task automatic testData();
    wr(2'd1, 2'b01, 16'h0006);
    wr(2'd2, 2'b11, 16'h1234);
    doneBit("R7 write in rd-all clears", 1'b0);
    pulseDone();
    rd(2'd2, rv); chk("R7 data value", rv, 16'h1234);
    doneBit("R8 read in rd-all clears", 1'b0);
    wr(2'd1, 2'b01, 16'h0008);
    pulseDone();
    rd(2'd2, rv);
    doneBit("R8 read in wr-all keeps", 1'b1);
    wr(2'd2, 2'b10, 16'hAB00);
    doneBit("R7 write in wr-all clears", 1'b0);
    rd(2'd2, rv); chk("R7 high lane only", rv, 16'hAB34);
    wr(2'd1, 2'b01, 16'h000A);
    pulseDone();
    wr(2'd2, 2'b01, 16'h0001);
    doneBit("R7 write in mark clears", 1'b0);
    wr(2'd1, 2'b01, 16'h0004);
    pulseDone();
    wr(2'd2, 2'b11, 16'h5555);
    doneBit("R7 write in search keeps", 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testMotion();
    testSelect();
    testIllegal();
    testGo();
    testIrq();
    testData();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule